// File: doc/BRIEF.md
# Control Endpoint Setup Capture Buffer

This block stores the eight-byte setup stage of a USB device control endpoint and lets the CPU read it back one byte at a time. The serial interface engine marks the start of each setup packet with a one-cycle strobe. It then pushes bytes with a byte-valid strobe. Once the eighth byte has landed, a ready flag tells the CPU that a whole packet is waiting. The CPU pulls bytes in order with a read strobe. Each strobe is answered one cycle later with the data, a valid pulse and a flag that marks the byte as unusable.

The USB side always wins. A new start strobe rewinds both the write and the read position and drops the ready flag. If the CPU was partway through the previous packet, its read is cut short and a sticky abort flag is raised; the CPU clears that flag with a write-one-to-clear strobe. Any byte the CPU requests while no complete packet is ready is marked unusable and does not move the read position. This is the case during a new reception and in the cycle of a start strobe. Because the read position is rewound on every start, a read that was abandoned part-way cannot shift the bytes of the next packet.

Top module: `setup_rx_buffer`

## Requirements
- R1: While reset is applied, and until the first stimulus after its release, setup_ready_o, abort_err_o, cpu_rd_vld_o and cpu_rd_bad_o are all 0.
- R2: The bytes written after a start strobe are read back by the CPU in the same order: the first byte written is the first byte read, up to the eighth.
- R3: setup_ready_o rises in the cycle after the eighth byte of a packet is written. Byte-valid strobes after the eighth byte and before the next start strobe change nothing.
- R4: setup_ready_o falls in the cycle after the CPU reads the eighth byte. The read position then returns to the first byte.
- R5: A start strobe clears setup_ready_o and rewinds both positions. A byte-valid strobe in the same cycle as the start strobe stores that byte as the first byte of the new packet.
- R6: A start strobe that arrives after the CPU has read one to seven bytes of the current packet sets abort_err_o. A start strobe with no partial read pending leaves it unchanged.
- R7: A read strobe issued while setup_ready_o is 0, or in the same cycle as a start strobe, returns cpu_rd_bad_o = 1 and does not advance the read position.
- R8: Each read strobe is answered exactly one cycle later by a one-cycle cpu_rd_vld_o pulse, with cpu_rd_data_o and cpu_rd_bad_o valid in that cycle. Without a read strobe, cpu_rd_vld_o stays 0.
- R9: cpu_err_clr_i clears abort_err_o in the next cycle. If a setting event happens in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| usb_start_i | input | 1 | Start-of-setup strobe from the serial interface engine |
| usb_wr_vld_i | input | 1 | Byte-valid strobe |
| usb_wr_data_i | input | 8 | Setup byte |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_err_clr_i | input | 1 | Write-one-to-clear for the abort flag |
| cpu_rd_data_o | output | 8 | Byte returned for the previous read strobe |
| cpu_rd_vld_o | output | 1 | Read response pulse |
| cpu_rd_bad_o | output | 1 | Returned byte is not part of a complete packet |
| setup_ready_o | output | 1 | A complete setup packet is waiting |
| abort_err_o | output | 1 | A partial read was cut short by a new packet |

## Verification
The hardest situation to reach from the ports is a new start strobe that lands while the CPU sits between the first and last byte of a packet. The strobe may also land in the very cycle of a read strobe, or together with the first byte-valid strobe. Directed sequences stop a read after three bytes, then restart the packet. They check the abort flag, the marked reads during reception and the realigned data of the next packet. A long run of random interleavings then drives all three strobes against a queue-based reference that is compared every clock. Starts are kept frequent enough that partial reads are cut short hundreds of times.

// File: rtl/setup_rx_pkg.sv
package setup_rx_pkg;
  localparam int unsigned SRX_DATA_W = 8;
  localparam int unsigned SRX_DEPTH  = 8;

  typedef struct packed {
    logic start;
    logic wr_last;
    logic rd_last;
    logic rd_busy;
  } srx_evt_t;
endpackage

// File: rtl/srx_rst_sync.sv
module srx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/srx_wr_ctrl.sv
module srx_wr_ctrl #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          wr_vld,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [DEPTH-1:0][DATA_W-1:0]  store,
  output logic                          wr_last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] wr_idx;
  logic             room;
  logic             wr_en;

  assign room    = (cnt_q < CNT_W'(DEPTH));
  assign wr_en   = wr_vld && (start || room);
  assign wr_idx  = start ? '0 : cnt_q[IDX_W-1:0];
  assign wr_last = wr_vld && !start && (cnt_q == CNT_W'(DEPTH - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (start)              cnt_d = wr_vld ? CNT_W'(1) : '0;
    else if (wr_vld && room) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       store[g] <= '0;
      else if (slot_en) store[g] <= wr_data;
    end
  end
endmodule

// File: rtl/srx_rd_ctrl.sv
module srx_rd_ctrl #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          rd_req,
  input  logic                          ready,
  input  logic [DEPTH-1:0][DATA_W-1:0]  store,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          rd_vld,
  output logic                          rd_bad,
  output logic                          rd_last,
  output logic                          rd_busy
);
  logic [IDX_W-1:0]  ptr_q, ptr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              vld_q, bad_q;
  logic              accept;
  logic              at_end;

  assign accept  = rd_req && ready && !start;
  assign at_end  = (ptr_q == IDX_W'(DEPTH - 1));
  assign rd_last = accept && at_end;
  assign rd_busy = (ptr_q != '0);

  always_comb begin
    ptr_d  = ptr_q;
    data_d = data_q;
    if (start)       ptr_d = '0;
    else if (accept) ptr_d = at_end ? '0 : ptr_q + IDX_W'(1);
    if (rd_req)      data_d = store[ptr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      data_q <= data_d;
      vld_q  <= rd_req;
      bad_q  <= rd_req && !accept;
    end
  end

  assign rd_data = data_q;
  assign rd_vld  = vld_q;
  assign rd_bad  = bad_q;
endmodule

// File: rtl/srx_flags.sv
module srx_flags
  import setup_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  srx_evt_t evt,
  input  logic     err_clr,
  output logic     ready,
  output logic     abort_err
);
  logic ready_q, ready_d;
  logic abort_q, abort_d;

  always_comb begin
    ready_d = ready_q;
    if (evt.start)        ready_d = 1'b0;
    else if (evt.wr_last) ready_d = 1'b1;
    else if (evt.rd_last) ready_d = 1'b0;

    abort_d = abort_q;
    if (evt.start && evt.rd_busy) abort_d = 1'b1;
    else if (err_clr)             abort_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      ready_q <= ready_d;
      abort_q <= abort_d;
    end
  end

  assign ready     = ready_q;
  assign abort_err = abort_q;
endmodule

// File: rtl/setup_rx_buffer.sv
module setup_rx_buffer
  import setup_rx_pkg::*;
#(
  parameter int unsigned DATA_W = SRX_DATA_W,
  parameter int unsigned DEPTH  = SRX_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usb_start_i,
  input  logic              usb_wr_vld_i,
  input  logic [DATA_W-1:0] usb_wr_data_i,
  input  logic              cpu_rd_i,
  input  logic              cpu_err_clr_i,
  output logic [DATA_W-1:0] cpu_rd_data_o,
  output logic              cpu_rd_vld_o,
  output logic              cpu_rd_bad_o,
  output logic              setup_ready_o,
  output logic              abort_err_o
);
  logic                         rst_n_int;
  logic [DEPTH-1:0][DATA_W-1:0] store;
  logic                         wr_last, rd_last, rd_busy;
  srx_evt_t                     evt;

  srx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  srx_wr_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst_n(rst_n_int), .start(usb_start_i),
    .wr_vld(usb_wr_vld_i), .wr_data(usb_wr_data_i),
    .store(store), .wr_last(wr_last)
  );

  srx_rd_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_n_int), .start(usb_start_i),
    .rd_req(cpu_rd_i), .ready(setup_ready_o), .store(store),
    .rd_data(cpu_rd_data_o), .rd_vld(cpu_rd_vld_o), .rd_bad(cpu_rd_bad_o),
    .rd_last(rd_last), .rd_busy(rd_busy)
  );

  assign evt = '{start: usb_start_i, wr_last: wr_last,
                 rd_last: rd_last, rd_busy: rd_busy};

  srx_flags u_flags (
    .clk(clk), .rst_n(rst_n_int), .evt(evt), .err_clr(cpu_err_clr_i),
    .ready(setup_ready_o), .abort_err(abort_err_o)
  );
endmodule

// File: rtl/setup_rx_buffer_chk.sv
module setup_rx_buffer_chk (
  input logic clk,
  input logic rst_n,
  input logic usb_start_i,
  input logic usb_wr_vld_i,
  input logic cpu_rd_i,
  input logic cpu_err_clr_i,
  input logic cpu_rd_vld_o,
  input logic cpu_rd_bad_o,
  input logic setup_ready_o,
  input logic abort_err_o,
  input logic rd_busy
);
  // R5
  start_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usb_start_i |=> !setup_ready_o);

  // R3
  ready_rise_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(setup_ready_o) |-> $past(usb_wr_vld_i) && !$past(usb_start_i));

  // R6
  abort_on_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usb_start_i && rd_busy |=> abort_err_o);

  // R7
  read_not_ready_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd_i && (!setup_ready_o || usb_start_i) |=> cpu_rd_vld_o && cpu_rd_bad_o);

  // R8
  read_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd_i |=> cpu_rd_vld_o);

  // R8
  no_spurious_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd_i |=> !cpu_rd_vld_o);

  // R9
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err_clr_i && !usb_start_i |=> !abort_err_o);

  // R9
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_err_clr_i && !usb_start_i |=> abort_err_o == $past(abort_err_o));
endmodule

bind setup_rx_buffer setup_rx_buffer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .usb_start_i(usb_start_i),
  .usb_wr_vld_i(usb_wr_vld_i), .cpu_rd_i(cpu_rd_i),
  .cpu_err_clr_i(cpu_err_clr_i), .cpu_rd_vld_o(cpu_rd_vld_o),
  .cpu_rd_bad_o(cpu_rd_bad_o), .setup_ready_o(setup_ready_o),
  .abort_err_o(abort_err_o), .rd_busy(rd_busy)
);

// File: tb/tb_setup_rx_buffer.sv
`timescale 1ns/1ps
module tb_setup_rx_buffer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, wvld = 1'b0, rd = 1'b0, clr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rvld, rbad, ready, abort;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit cmp_en = 1'b0;

  always #2.5 clk = ~clk;

  setup_rx_buffer dut (
    .clk(clk), .rst_n(rst_n), .usb_start_i(start), .usb_wr_vld_i(wvld),
    .usb_wr_data_i(wdata), .cpu_rd_i(rd), .cpu_err_clr_i(clr),
    .cpu_rd_data_o(rdata), .cpu_rd_vld_o(rvld), .cpu_rd_bad_o(rbad),
    .setup_ready_o(ready), .abort_err_o(abort)
  );

  // behavioural reference: packet bytes kept in a queue, positions as integers
  byte unsigned pkt[$];
  int  m_rpos = 0;
  bit  m_ready = 0, m_abort = 0, m_vld = 0, m_bad = 0;
  byte unsigned m_data = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      pkt.delete(); m_rpos = 0; m_ready = 0; m_abort = 0; m_vld = 0; m_bad = 0;
    end else begin
      bit ok_rd;
      bit partial;
      partial = (m_rpos != 0);
      ok_rd = rd && m_ready && !start;
      m_vld = rd;
      m_bad = rd && !ok_rd;
      if (rd && m_rpos < pkt.size()) m_data = pkt[m_rpos];
      if (start) begin
        pkt.delete();
        if (wvld) pkt.push_back(wdata);
        m_rpos = 0;
        m_ready = 0;
      end else begin
        if (wvld && pkt.size() < 8) begin
          pkt.push_back(wdata);
          if (pkt.size() == 8) m_ready = 1;
        end
        if (ok_rd) begin
          m_rpos++;
          if (m_rpos == 8) begin m_rpos = 0; m_ready = 0; end
        end
      end
      if (start && partial) m_abort = 1;
      else if (clr) m_abort = 0;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cmp_en) begin
      chk("R3", "setup_ready", ready, m_ready);
      chk("R6", "abort_err", abort, m_abort);
      chk("R8", "rd_vld", rvld, m_vld);
      if (m_vld) chk("R7", "rd_bad", rbad, m_bad);
      if (m_vld && !m_bad) chk("R2", "rd_data", rdata, m_data);
    end
    if (cyc > 60000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(bit s, bit v, byte unsigned d, bit r, bit c);
    @(negedge clk);
    start = s; wvld = v; wdata = d; rd = r; clr = c;
    @(negedge clk);
    start = 0; wvld = 0; rd = 0; clr = 0;
  endtask

  task automatic send_pkt(byte unsigned base);
    drive(1, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) drive(0, 1, byte'(base + i), 0, 0);
  endtask

  initial begin
    idle(3);
    chk("R1", "ready in reset", ready, 0);
    chk("R1", "abort in reset", abort, 0);
    chk("R1", "rd_vld in reset", rvld, 0);
    chk("R1", "rd_bad in reset", rbad, 0);
    rst_n = 1;
    idle(4);
    cmp_en = 1;
    chk("R1", "ready after reset", ready, 0);

    // full packet, extra byte ignored, full read, extra read marked
    send_pkt(8'h10);
    chk("R3", "ready after eighth byte", ready, 1);
    drive(0, 1, 8'hEE, 0, 0);
    for (int i = 0; i < 8; i++) begin
      drive(0, 0, 0, 1, 0);
      chk("R2", "ordered byte", rdata, 8'h10 + i);
    end
    chk("R4", "ready after eighth read", ready, 0);
    drive(0, 0, 0, 1, 0);
    chk("R7", "read with no packet", rbad, 1);

    // partial read cut short by new packet
    send_pkt(8'h40);
    for (int i = 0; i < 3; i++) drive(0, 0, 0, 1, 0);
    drive(1, 0, 0, 0, 0);
    chk("R6", "abort after partial read", abort, 1);
    drive(0, 1, 8'h80, 1, 0);
    chk("R7", "read during reception", rbad, 1);
    for (int i = 1; i < 8; i++) drive(0, 1, byte'(8'h80 + i), 0, 0);
    drive(0, 0, 0, 1, 0);
    chk("R5", "first byte after restart", rdata, 8'h80);
    drive(0, 0, 0, 0, 1);
    chk("R9", "abort cleared", abort, 0);

    // start with byte in same cycle, read in start cycle, set wins over clear
    drive(0, 0, 0, 1, 0);
    drive(1, 1, 8'hA5, 1, 1);
    chk("R6", "set beats clear", abort, 1);
    chk("R7", "read in start cycle", rbad, 1);
    for (int i = 1; i < 8; i++) drive(0, 1, byte'(8'hA0 + i), 0, 0);
    drive(0, 0, 0, 1, 0);
    chk("R5", "byte stored with start", rdata, 8'hA5);
    drive(0, 0, 0, 0, 1);
    for (int i = 1; i < 8; i++) drive(0, 0, 0, 1, 0);
    drive(1, 0, 0, 0, 0);
    chk("R6", "no abort without partial read", abort, 0);

    // random interleaving
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      start = ($urandom_range(0, 29) == 0);
      wvld  = ($urandom_range(0, 2) == 0);
      wdata = 8'($urandom);
      rd    = ($urandom_range(0, 2) == 0);
      clr   = ($urandom_range(0, 19) == 0);
    end
    @(negedge clk);
    start = 0; wvld = 0; rd = 0; clr = 0;
    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule